// File: doc/BRIEF.md
# Sixteen-Bit Shift and Rotate Unit with Status Flags

This block is the shift and rotate datapath slice of a small processor core. In a single cycle it turns an operand, a carry input, an operation code and a shift amount into a result and a set of condition-flag updates. It has no state and no clock. The enclosing pipeline latches the outputs together with the rest of the execute stage.

Ten operations are supported. There are three single-bit shifts (arithmetic right, logical right, left). There are three multi-bit barrel shifts of the same kinds, whose amount comes from a register or a 5-bit literal. There are four rotates by one position: left and right, each either through the carry or around the word itself. Each of the four flags (C, N, OV, Z) has a value output and a write-enable output. The register file commits a flag only when its enable is high. Which flags an operation may touch depends on its form.

Top module: `shr_unit`

## Requirements
- R1: Op code 0 (single arithmetic right shift) gives {a[15], a[15:1]}, writes C with a[0], and writes OV with 0.
- R2: Op code 1 (single logical right shift) gives {0, a[15:1]}, writes C with a[0], and writes OV with 0.
- R3: Op code 2 (single left shift) gives {a[14:0], 0}, writes C with a[15], and writes OV with result[15] XOR a[15].
- R4: Op codes 3, 4 and 5 (barrel arithmetic right, logical right, left) shift by the 5-bit amount. Amounts 0 to 15 behave like repeated single shifts. Only the N and Z enables are raised.
- R5: For a barrel amount of 16 or more, the result is 0 for op codes 4 and 5, and 16 copies of a[15] for op code 3.
- R6: Op code 6 (rotate left through carry) gives {a[14:0], cin} and writes C with a[15]. Op code 7 (rotate right through carry) gives {cin, a[15:1]} and writes C with a[0]. Neither operation raises the OV enable.
- R7: Op code 8 (rotate left without carry) gives {a[14:0], a[15]}. Op code 9 (rotate right without carry) gives {a[0], a[15:1]}. Both raise only the N and Z enables.
- R8: For every op code 0 to 9, the N and Z enables are high, N equals result[15], and Z is 1 exactly when the result is zero.
- R9: Op codes 10 to 15 pass the operand through unchanged and raise no enable. A flag value output whose enable is low reads 0.
- R10: Every output is a combinational function of the present inputs, so a result is valid in the same cycle as its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 16 | Value to shift or rotate |
| carry_i | input | 1 | Current C flag, used by the rotates through carry |
| op_i | input | 4 | Operation code (0 to 9 defined) |
| shamt_i | input | 5 | Barrel shift amount (register or literal source) |
| result_o | output | 16 | Shifted or rotated value |
| c_o | output | 1 | New C value |
| n_o | output | 1 | New N value |
| ov_o | output | 1 | New OV value |
| z_o | output | 1 | New Z value |
| c_we_o | output | 1 | Write enable for C |
| n_we_o | output | 1 | Write enable for N |
| ov_we_o | output | 1 | Write enable for OV |
| z_we_o | output | 1 | Write enable for Z |

## Verification
Every result and flag is due zero cycles after its stimulus, because the block is purely combinational. The bench therefore drives a new input vector on each falling edge. It compares the full output bundle against its behavioural model one nanosecond later, inside that same clock period and well away from the rising edge. The model computes barrel shifts by repeating a one-position step as many times as the amount asks. This keeps it independent of the stage-by-stage structure in the design.

// File: rtl/shr_pkg.sv
package shr_pkg;
   localparam int unsigned OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ASR1 = 4'd0,
      OP_LSR1 = 4'd1,
      OP_SL1  = 4'd2,
      OP_ASRN = 4'd3,
      OP_LSRN = 4'd4,
      OP_SLN  = 4'd5,
      OP_RLC  = 4'd6,
      OP_RRC  = 4'd7,
      OP_RLNC = 4'd8,
      OP_RRNC = 4'd9
   } shr_op_e;

   function automatic logic op_is_defined(input logic [OP_W-1:0] op);
      return (op <= OP_RRNC);
   endfunction

   function automatic logic op_is_barrel(input logic [OP_W-1:0] op);
      return (op == OP_ASRN) || (op == OP_LSRN) || (op == OP_SLN);
   endfunction

   function automatic logic op_writes_c(input logic [OP_W-1:0] op);
      return (op <= OP_SL1) || (op == OP_RLC) || (op == OP_RRC);
   endfunction

   function automatic logic op_writes_ov(input logic [OP_W-1:0] op);
      return (op <= OP_SL1);
   endfunction
endpackage

// File: rtl/shr_onebit.sv
module shr_onebit
   import shr_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic             cin_i,
   input  logic [OP_W-1:0]  op_i,
   output logic [WIDTH-1:0] res_o,
   output logic             out_bit_o
);
   localparam int unsigned MSB = WIDTH - 1;

   always_comb begin
      res_o     = a_i;
      out_bit_o = 1'b0;
      case (op_i)
         OP_ASR1: begin
            res_o     = {a_i[MSB], a_i[MSB:1]};
            out_bit_o = a_i[0];
         end
         OP_LSR1: begin
            res_o     = {1'b0, a_i[MSB:1]};
            out_bit_o = a_i[0];
         end
         OP_SL1: begin
            res_o     = {a_i[MSB-1:0], 1'b0};
            out_bit_o = a_i[MSB];
         end
         OP_RLC: begin
            res_o     = {a_i[MSB-1:0], cin_i};
            out_bit_o = a_i[MSB];
         end
         OP_RRC: begin
            res_o     = {cin_i, a_i[MSB:1]};
            out_bit_o = a_i[0];
         end
         OP_RLNC: res_o = {a_i[MSB-1:0], a_i[MSB]};
         OP_RRNC: res_o = {a_i[0], a_i[MSB:1]};
         default: begin
            res_o     = a_i;
            out_bit_o = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/shr_barrel.sv
module shr_barrel #(
   parameter int unsigned WIDTH   = 16,
   parameter int unsigned SHAMT_W = 5,
   parameter bit          LEFT    = 1'b0,
   parameter int unsigned IMPL    = 0
) (
   input  logic [WIDTH-1:0]   a_i,
   input  logic [SHAMT_W-1:0] amt_i,
   input  logic               fill_i,
   output logic [WIDTH-1:0]   res_o
);
   localparam logic [SHAMT_W:0] WIDTH_AMT = (SHAMT_W + 1)'(WIDTH);

   generate
      if (IMPL == 1) begin : g_operator
         logic [2*WIDTH-1:0] ext;
         logic               too_far;
         assign too_far = ({1'b0, amt_i} >= WIDTH_AMT);
         if (LEFT) begin : g_left
            assign ext   = {{WIDTH{1'b0}}, a_i} << amt_i;
            assign res_o = too_far ? '0 : ext[WIDTH-1:0];
         end else begin : g_right
            assign ext   = {{WIDTH{fill_i}}, a_i} >> amt_i;
            assign res_o = too_far ? {WIDTH{fill_i}} : ext[WIDTH-1:0];
         end
      end else begin : g_stages
         for (genvar i = 0; i < SHAMT_W; i++) begin : g_st
            localparam longint unsigned STEP = 64'd1 << i;
            logic [WIDTH-1:0] din;
            logic [WIDTH-1:0] q;
            if (i == 0) begin : g_first
               assign din = a_i;
            end else begin : g_next
               assign din = g_st[i-1].q;
            end
            if (STEP >= WIDTH) begin : g_flush
               if (LEFT) begin : g_l
                  assign q = amt_i[i] ? '0 : din;
               end else begin : g_r
                  assign q = amt_i[i] ? {WIDTH{fill_i}} : din;
               end
            end else begin : g_move
               localparam int unsigned S = int'(STEP);
               if (LEFT) begin : g_l
                  assign q = amt_i[i] ? {din[WIDTH-1-S:0], {S{1'b0}}} : din;
               end else begin : g_r
                  assign q = amt_i[i] ? {{S{fill_i}}, din[WIDTH-1:S]} : din;
               end
            end
         end
         assign res_o = g_st[SHAMT_W-1].q;
      end
   endgenerate
endmodule

// File: rtl/shr_flags.sv
module shr_flags
   import shr_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [OP_W-1:0]  op_i,
   input  logic [WIDTH-1:0] res_i,
   input  logic             out_bit_i,
   input  logic             src_msb_i,
   output logic             c_o,
   output logic             n_o,
   output logic             ov_o,
   output logic             z_o,
   output logic             c_we_o,
   output logic             n_we_o,
   output logic             ov_we_o,
   output logic             z_we_o
);
   logic defined;
   logic ov_raw;

   assign defined = op_is_defined(op_i);
   assign ov_raw  = (op_i == OP_SL1) ? (res_i[WIDTH-1] ^ src_msb_i) : 1'b0;

   assign c_we_o  = op_writes_c(op_i);
   assign ov_we_o = op_writes_ov(op_i);
   assign n_we_o  = defined;
   assign z_we_o  = defined;

   assign c_o  = c_we_o  & out_bit_i;
   assign ov_o = ov_we_o & ov_raw;
   assign n_o  = n_we_o  & res_i[WIDTH-1];
   assign z_o  = z_we_o  & ~(|res_i);
endmodule

// File: rtl/shr_unit.sv
module shr_unit
   import shr_pkg::*;
#(
   parameter int unsigned WIDTH       = 16,
   parameter int unsigned SHAMT_W     = 5,
   parameter int unsigned BARREL_IMPL = 0
) (
   input  logic [WIDTH-1:0]   operand_i,
   input  logic               carry_i,
   input  logic [OP_W-1:0]    op_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   output logic [WIDTH-1:0]   result_o,
   output logic               c_o,
   output logic               n_o,
   output logic               ov_o,
   output logic               z_o,
   output logic               c_we_o,
   output logic               n_we_o,
   output logic               ov_we_o,
   output logic               z_we_o
);
   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("shr_unit: WIDTH must be at least 2");
      end
      if (SHAMT_W < 1 || SHAMT_W > 16) begin : g_bad_shamt
         $error("shr_unit: SHAMT_W must lie in 1..16");
      end
      if (BARREL_IMPL > 1) begin : g_bad_impl
         $error("shr_unit: BARREL_IMPL must be 0 or 1");
      end
   endgenerate

   logic [WIDTH-1:0] single_res;
   logic             single_out;
   logic [WIDTH-1:0] left_res;
   logic [WIDTH-1:0] right_res;
   logic             right_fill;

   shr_onebit #(.WIDTH(WIDTH)) u_onebit (
      .a_i       (operand_i),
      .cin_i     (carry_i),
      .op_i      (op_i),
      .res_o     (single_res),
      .out_bit_o (single_out)
   );

   assign right_fill = (op_i == OP_ASRN) & operand_i[MSB];

   shr_barrel #(
      .WIDTH(WIDTH), .SHAMT_W(SHAMT_W), .LEFT(1'b1), .IMPL(BARREL_IMPL)
   ) u_barrel_left (
      .a_i    (operand_i),
      .amt_i  (shamt_i),
      .fill_i (1'b0),
      .res_o  (left_res)
   );

   shr_barrel #(
      .WIDTH(WIDTH), .SHAMT_W(SHAMT_W), .LEFT(1'b0), .IMPL(BARREL_IMPL)
   ) u_barrel_right (
      .a_i    (operand_i),
      .amt_i  (shamt_i),
      .fill_i (right_fill),
      .res_o  (right_res)
   );

   always_comb begin
      if (op_is_barrel(op_i)) begin
         result_o = (op_i == OP_SLN) ? left_res : right_res;
      end else begin
         result_o = single_res;
      end
   end

   shr_flags #(.WIDTH(WIDTH)) u_flags (
      .op_i      (op_i),
      .res_i     (result_o),
      .out_bit_i (single_out),
      .src_msb_i (operand_i[MSB]),
      .c_o       (c_o),
      .n_o       (n_o),
      .ov_o      (ov_o),
      .z_o       (z_o),
      .c_we_o    (c_we_o),
      .n_we_o    (n_we_o),
      .ov_we_o   (ov_we_o),
      .z_we_o    (z_we_o)
   );
endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk #(
   parameter int unsigned WIDTH   = 16,
   parameter int unsigned SHAMT_W = 5
) (
   input logic [WIDTH-1:0]   operand_i,
   input logic               carry_i,
   input logic [3:0]         op_i,
   input logic [SHAMT_W-1:0] shamt_i,
   input logic [WIDTH-1:0]   result_o,
   input logic               c_o,
   input logic               n_o,
   input logic               ov_o,
   input logic               z_o,
   input logic               c_we_o,
   input logic               n_we_o,
   input logic               ov_we_o,
   input logic               z_we_o
);
   logic known;
   assign known = !$isunknown({operand_i, carry_i, op_i, shamt_i});

   always_comb begin
      if (known) begin
         // R8: every defined op raises N and Z, and both track the result
         p_nz_track_r8: assert ((op_i > 4'd9) ||
            (n_we_o && z_we_o && (n_o == result_o[WIDTH-1]) &&
             (z_o == (result_o == '0))))
            else $error("p_nz_track_r8");
         // R4: barrel shifts never raise C or OV
         p_barrel_nz_only_r4: assert (!((op_i >= 4'd3) && (op_i <= 4'd5)) ||
            (!c_we_o && !ov_we_o))
            else $error("p_barrel_nz_only_r4");
         // R6: rotates through carry write C but never OV
         p_rot_carry_r6: assert (!((op_i == 4'd6) || (op_i == 4'd7)) ||
            (c_we_o && !ov_we_o))
            else $error("p_rot_carry_r6");
         // R7: rotates without carry raise neither C nor OV
         p_rot_plain_r7: assert (!((op_i == 4'd8) || (op_i == 4'd9)) ||
            (!c_we_o && !ov_we_o && (result_o != '0 || operand_i == '0)))
            else $error("p_rot_plain_r7");
         // R9: undefined codes pass the operand and enable nothing
         p_undef_pass_r9: assert ((op_i <= 4'd9) ||
            ((result_o == operand_i) && !c_we_o && !n_we_o && !ov_we_o && !z_we_o))
            else $error("p_undef_pass_r9");
         // R3: a left shift by one sets OV on a change of the sign bit
         p_sl_ov_r3: assert ((op_i != 4'd2) ||
            (ov_o == (operand_i[WIDTH-1] != operand_i[WIDTH-2])))
            else $error("p_sl_ov_r3");
      end
   end
endmodule

bind shr_unit shr_unit_chk #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_chk (
   .operand_i (operand_i),
   .carry_i   (carry_i),
   .op_i      (op_i),
   .shamt_i   (shamt_i),
   .result_o  (result_o),
   .c_o       (c_o),
   .n_o       (n_o),
   .ov_o      (ov_o),
   .z_o       (z_o),
   .c_we_o    (c_we_o),
   .n_we_o    (n_we_o),
   .ov_we_o   (ov_we_o),
   .z_we_o    (z_we_o)
);

// File: tb/shr_unit_test.sv
`timescale 1ns/1ps
module shr_unit_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] operand;
   logic        carry;
   logic [3:0]  op;
   logic [4:0]  shamt;
   logic [15:0] result;
   logic        c, n, ov, z, c_we, n_we, ov_we, z_we;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   shr_unit uut (
      .operand_i (operand), .carry_i (carry), .op_i (op), .shamt_i (shamt),
      .result_o (result), .c_o (c), .n_o (n), .ov_o (ov), .z_o (z),
      .c_we_o (c_we), .n_we_o (n_we), .ov_we_o (ov_we), .z_we_o (z_we)
   );

   // Behavioural model: outputs packed as {result, c,n,ov,z, cwe,nwe,ovwe,zwe}
   function automatic logic [23:0] model(input logic [15:0] a, input logic ci,
                                         input int code, input int amt);
      logic [15:0] r = a;
      logic cv = 0, ovv = 0, cw = 0, ow = 0, nzw = 1;
      case (code)
         0: begin r = a >> 1; r[15] = a[15]; cv = a[0]; cw = 1; ow = 1; end
         1: begin r = a >> 1; cv = a[0]; cw = 1; ow = 1; end
         2: begin r = a << 1; cv = a[15]; cw = 1; ow = 1; ovv = r[15] ^ a[15]; end
         3: for (int k = 0; k < amt; k++) begin r = r >> 1; r[15] = a[15]; end
         4: for (int k = 0; k < amt; k++) r = r >> 1;
         5: for (int k = 0; k < amt; k++) r = r << 1;
         6: begin r = (a << 1) | 16'(ci); cv = a[15]; cw = 1; end
         7: begin r = (a >> 1) | (16'(ci) << 15); cv = a[0]; cw = 1; end
         8: r = (a << 1) | (a >> 15);
         9: r = (a >> 1) | (a << 15);
         default: nzw = 0;
      endcase
      return {r, cv & cw, nzw & r[15], ovv & ow, nzw & (r == 16'h0),
              cw, nzw, ow, nzw};
   endfunction

   function automatic string tag_of(input int code, input int amt);
      case (code)
         0: return "R1/R8";
         1: return "R2/R8";
         2: return "R3/R8";
         3, 4, 5: return (amt >= 16) ? "R5/R8" : "R4/R8";
         6, 7: return "R6/R8";
         8, 9: return "R7/R8";
         default: return "R9";
      endcase
   endfunction

   // Drive on a falling edge, compare 1 ns later in the same cycle (R10).
   task automatic apply(input logic [15:0] a, input logic ci, input int code,
                        input int amt, input string extra);
      logic [23:0] exp, act;
      @(negedge clk);
      operand = a; carry = ci; op = 4'(code); shamt = 5'(amt);
      #1;
      exp = model(a, ci, code, amt);
      act = {result, c, n, ov, z, c_we, n_we, ov_we, z_we};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s%s op=%0d a=%h cin=%0d amt=%0d actual=%h expected=%h",
                  tag_of(code, amt), extra, code, a, ci, amt, act, exp);
      end
   endtask

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      operand = '0; carry = 0; op = '0; shamt = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // quiet starting point: zero operand, op 0 (R1, Z set)
      apply(16'h0000, 0, 0, 0, "");
      // R1 sign copy, R2 zero fill
      apply(16'h8001, 0, 0, 0, "");
      apply(16'h8001, 0, 1, 0, "");
      // R3 overflow on sign change and without it
      apply(16'h4000, 0, 2, 0, "");
      apply(16'hC000, 0, 2, 0, "");
      // R4 barrel amounts
      apply(16'h8421, 0, 3, 4, "");
      apply(16'h8421, 0, 4, 15, "");
      apply(16'h00F1, 0, 5, 0, "");
      apply(16'h00F1, 0, 5, 7, "");
      // R5 amounts of 16 and more
      apply(16'h8000, 0, 3, 16, "");
      apply(16'h7FFF, 0, 3, 31, "");
      apply(16'hFFFF, 0, 4, 16, "");
      apply(16'hFFFF, 0, 5, 20, "");
      // R6 carry in and out
      apply(16'h8000, 1, 6, 0, "");
      apply(16'h0001, 1, 7, 0, "");
      apply(16'h0001, 0, 7, 0, "");
      // R7 carry input has no effect
      apply(16'h8001, 1, 8, 0, "");
      apply(16'h8001, 1, 9, 0, "");
      // R9 undefined codes
      apply(16'hBEEF, 1, 10, 3, "");
      apply(16'h1234, 0, 15, 17, "");
      // R10 back-to-back changes settle within the cycle
      apply(16'h0002, 0, 1, 0, " R10");
      apply(16'h0002, 0, 2, 0, " R10");
      // mixed sweep over all codes and amounts
      for (int i = 0; i < 3000; i++) begin
         apply(16'($urandom), 1'($urandom), int'($urandom_range(0, 15)),
               int'($urandom_range(0, 31)), "");
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule